// File: doc/BRIEF.md
# Trap Entry and Vectoring Sequencer

This block sits beside a CPU core and takes over the moment an exceptional event must redirect execution. Three kinds of event can arrive: a software trap raised by an instruction, carrying a 7-bit trap number; one of eight hardware trap conditions; and an ordinary interrupt with its priority level and vector number. In its idle state the block picks a single winner. It snapshots the status word, code segment and instruction pointer, and computes the vector address as the trap number times four. Every vector therefore lands in the byte range 0x000 to 0x1FC.

After acceptance the sequencer saves the context onto a descending system stack, one 16-bit word per clock. Each write goes to the stack pointer minus two, and the decremented pointer is presented for update. It then loads the new instruction pointer and, when segmentation is on, forces the code segment to zero. Hardware trap conditions are caught in sticky flags, so a lower-priority condition seen alongside a higher one is serviced by a later entry. At acceptance of a hardware trap the block reports whether the faulting instruction is completed or cancelled, following a per-source parameter.

The state machine has five states. ST_IDLE arbitrates. ST_PUSH_PSW writes the status word. ST_PUSH_CSP writes the code segment and is entered only when segmentation was enabled at acceptance. ST_PUSH_IP writes the instruction pointer. ST_LOAD writes the new pointers and pulses done. The transitions are:
- ST_IDLE to ST_PUSH_PSW when any event wins.
- ST_PUSH_PSW to ST_PUSH_CSP when segmentation is enabled, otherwise to ST_PUSH_IP.
- ST_PUSH_CSP to ST_PUSH_IP.
- ST_PUSH_IP to ST_LOAD.
- ST_LOAD back to ST_IDLE.

Top module: `trap_seq`

## Requirements
- R1: After reset, busy, done, all acknowledges and all write enables are low, and no hardware trap is pending.
- R2: An accepted software trap pulses sw_ack in its acceptance cycle and loads ip_new equal to sw_num shifted left by two, so trap number 127 gives 0x01FC and trap number 0 gives 0x0000.
- R3: With seg_en high at acceptance, three consecutive cycles write the status word to sp_in-2, the code segment (zero-extended) to sp_in-4 and the instruction pointer to sp_in-6. In each of those cycles sp_we is high and sp_next equals the write address.
- R4: With seg_en low at acceptance, only the status word (sp_in-2) and the instruction pointer (sp_in-4) are pushed, and csp_we stays low.
- R5: When seg_en was high at acceptance, the load cycle asserts csp_we with csp_new equal to zero.
- R6: A software trap never asserts irq_ack, which is the only way the block clears an interrupt request flag. Its load cycle keeps psw_we low, so the priority level (psw bits 15:12) is unchanged.
- R7: An interrupt is accepted only when irq_level is strictly greater than psw_in bits 15:12. Its entry vectors to irq_num shifted left by two, and the load cycle writes psw_new with bits 15:12 set to irq_level and the other bits kept.
- R8: A pending hardware trap wins over a software trap and over an interrupt of any level. Its load cycle writes psw_new with bits 15:12 set to 0xF and the other bits kept.
- R9: Among pending hardware sources, index 0 has the highest priority. Losing sources stay latched, even after their input drops, and are entered one after another in index order.
- R10: In the acceptance cycle of hardware source i, insn_cancel pulses if HW_CANCEL bit i is set and insn_complete pulses otherwise. The vector is HW_TNUM field i shifted left by two.
- R11: busy is high from the cycle after acceptance through the load cycle. done is high only in the load cycle, together with ip_we.
- R12: When a software trap and an eligible interrupt arrive in the same cycle with no hardware trap pending, the software trap wins.
- R13: While busy, no software trap or interrupt is acknowledged. A software request still held at the end of the sequence is accepted in the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_en | input | 1 | Segmentation enabled |
| sw_req | input | 1 | Software trap request |
| sw_num | input | 7 | Software trap number |
| hw_cond | input | 8 | Hardware trap conditions, index 0 highest |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 4 | Interrupt priority level |
| irq_num | input | 7 | Interrupt vector number |
| psw_in | input | 16 | Current status word, level in bits 15:12 |
| csp_in | input | 8 | Current code segment pointer |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| sw_ack | output | 1 | Software trap accepted |
| irq_ack | output | 1 | Interrupt accepted, clears its request flag |
| insn_complete | output | 1 | Hardware trap accepted, faulting instruction completes |
| insn_cancel | output | 1 | Hardware trap accepted, faulting instruction cancelled |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Entry finished this cycle |
| mem_we | output | 1 | Stack word write |
| mem_addr | output | 16 | Stack write byte address |
| mem_wdata | output | 16 | Stack write data |
| sp_we | output | 1 | Stack pointer update |
| sp_next | output | 16 | New stack pointer |
| ip_we | output | 1 | Instruction pointer load |
| ip_new | output | 16 | Vector address |
| csp_we | output | 1 | Code segment load |
| csp_new | output | 8 | New code segment (zero) |
| psw_we | output | 1 | Status word load |
| psw_new | output | 16 | New status word |

## Verification
The hardest case to reach is several hardware conditions arriving in one cycle while other requests compete. Only a sequence of entries then shows that the losing sources stayed latched and are drained in index order after their inputs have dropped. The random stimulus fires sparse bursts of conditions together with software and interrupt requests, and the bench's own model of the pending set predicts each entry. A directed case raises all eight sources at once. Another holds a software request across a busy sequence to show it is refused until idle.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSW,
        ST_PUSH_CSP,
        ST_PUSH_IP,
        ST_LOAD
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_HW,
        EV_SW,
        EV_IRQ
    } event_t;

endpackage

// File: rtl/trap_flags.sv
module trap_flags #(
    parameter int NHW   = 8,
    parameter int IDX_W = (NHW > 1) ? $clog2(NHW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NHW-1:0]   cond,
    input  logic             take,
    output logic [NHW-1:0]   pend,
    output logic             any,
    output logic [IDX_W-1:0] win_idx
);

    logic [NHW-1:0] flag_q;
    logic [NHW-1:0] seen;
    logic [NHW-1:0] win;

    // A condition counts in the cycle it appears, as well as once latched.
    assign pend = flag_q | cond;
    assign any  = |pend;

    // Prefix chain: a source wins when no lower index is pending.
    assign seen[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 0; gi < NHW; gi++) begin : g_pick
            if (gi > 0) begin : g_chain
                assign seen[gi] = seen[gi-1] | pend[gi-1];
            end
            assign win[gi] = pend[gi] & ~seen[gi];
        end
    endgenerate

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NHW; i++) begin
            if (win[i]) win_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= pend & ~(take ? win : '0);
    end

endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
#(
    parameter int               NHW       = 8,
    parameter int               TNUM_W    = 7,
    parameter int               LVL_W     = 4,
    parameter int               IDX_W     = 3,
    parameter logic [NHW*TNUM_W-1:0] HW_TNUM = '0,
    parameter logic [NHW-1:0]   HW_CANCEL = '0
) (
    input  logic              hw_any,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic              sw_req,
    input  logic [TNUM_W-1:0] sw_num,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [TNUM_W-1:0] irq_num,
    input  logic [LVL_W-1:0]  cur_level,
    output event_t            ev,
    output logic [TNUM_W-1:0] tnum,
    output logic              cancel
);

    always_comb begin
        ev     = EV_NONE;
        tnum   = '0;
        cancel = 1'b0;
        if (hw_any) begin
            ev     = EV_HW;
            tnum   = HW_TNUM[hw_idx*TNUM_W +: TNUM_W];
            cancel = HW_CANCEL[hw_idx];
        end else if (sw_req) begin
            ev   = EV_SW;
            tnum = sw_num;
        end else if (irq_req && (irq_level > cur_level)) begin
            ev   = EV_IRQ;
            tnum = irq_num;
        end
    end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int                    NHW       = 8,
    parameter int                    TNUM_W    = 7,
    parameter int                    LVL_W     = 4,
    parameter int                    WORD_W    = 16,
    parameter int                    SEG_W     = 8,
    parameter logic [NHW*TNUM_W-1:0] HW_TNUM   = {7'h0F, 7'h0E, 7'h0D, 7'h0C,
                                                  7'h0B, 7'h0A, 7'h04, 7'h02},
    parameter logic [NHW-1:0]        HW_CANCEL = 8'b1010_0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_en,
    input  logic              sw_req,
    input  logic [TNUM_W-1:0] sw_num,
    input  logic [NHW-1:0]    hw_cond,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [TNUM_W-1:0] irq_num,
    input  logic [WORD_W-1:0] psw_in,
    input  logic [SEG_W-1:0]  csp_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] sp_in,
    output logic              sw_ack,
    output logic              irq_ack,
    output logic              insn_complete,
    output logic              insn_cancel,
    output logic              busy,
    output logic              done,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              sp_we,
    output logic [WORD_W-1:0] sp_next,
    output logic              ip_we,
    output logic [WORD_W-1:0] ip_new,
    output logic              csp_we,
    output logic [SEG_W-1:0]  csp_new,
    output logic              psw_we,
    output logic [WORD_W-1:0] psw_new
);

    localparam int IDX_W  = (NHW > 1) ? $clog2(NHW) : 1;
    localparam int PAD_W  = WORD_W - TNUM_W - 2;
    localparam int KEEP_W = WORD_W - LVL_W;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    seq_state_t        state_q, state_d;
    event_t            ev, kind_q;
    logic              hw_any, cancel, take, accept;
    logic [NHW-1:0]    hw_pend;
    logic [IDX_W-1:0]  hw_idx;
    logic [TNUM_W-1:0] tnum, tnum_q;
    logic [WORD_W-1:0] sp_q, psw_q, ip_q, sp_dec;
    logic [SEG_W-1:0]  csp_q;
    logic [LVL_W-1:0]  lvl_q, lvl_d;
    logic              seg_q;

    trap_flags #(.NHW(NHW), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (hw_cond),
        .take    (take),
        .pend    (hw_pend),
        .any     (hw_any),
        .win_idx (hw_idx)
    );

    trap_select #(
        .NHW(NHW), .TNUM_W(TNUM_W), .LVL_W(LVL_W), .IDX_W(IDX_W),
        .HW_TNUM(HW_TNUM), .HW_CANCEL(HW_CANCEL)
    ) u_sel (
        .hw_any    (hw_any),
        .hw_idx    (hw_idx),
        .sw_req    (sw_req),
        .sw_num    (sw_num),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .irq_num   (irq_num),
        .cur_level (psw_in[WORD_W-1 -: LVL_W]),
        .ev        (ev),
        .tnum      (tnum),
        .cancel    (cancel)
    );

    assign accept = (state_q == ST_IDLE) && (ev != EV_NONE);
    assign take   = accept && (ev == EV_HW);
    assign sp_dec = sp_q - STEP;

    always_comb begin
        unique case (ev)
            EV_HW:   lvl_d = {LVL_W{1'b1}};
            EV_IRQ:  lvl_d = irq_level;
            default: lvl_d = psw_in[WORD_W-1 -: LVL_W];
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ev != EV_NONE) state_d = ST_PUSH_PSW;
            ST_PUSH_PSW: state_d = seg_q ? ST_PUSH_CSP : ST_PUSH_IP;
            ST_PUSH_CSP: state_d = ST_PUSH_IP;
            ST_PUSH_IP:  state_d = ST_LOAD;
            ST_LOAD:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and context snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= EV_NONE;
            tnum_q  <= '0;
            sp_q    <= '0;
            psw_q   <= '0;
            csp_q   <= '0;
            ip_q    <= '0;
            lvl_q   <= '0;
            seg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q <= ev;
                tnum_q <= tnum;
                sp_q   <= sp_in;
                psw_q  <= psw_in;
                csp_q  <= csp_in;
                ip_q   <= ip_in;
                lvl_q  <= lvl_d;
                seg_q  <= seg_en;
            end else if (state_q inside {ST_PUSH_PSW, ST_PUSH_CSP, ST_PUSH_IP}) begin
                sp_q <= sp_dec;
            end
        end
    end

    // Outputs
    always_comb begin
        sw_ack        = 1'b0;
        irq_ack       = 1'b0;
        insn_complete = 1'b0;
        insn_cancel   = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = sp_dec;
        mem_wdata     = '0;
        sp_we         = 1'b0;
        sp_next       = sp_dec;
        ip_we         = 1'b0;
        ip_new        = {{PAD_W{1'b0}}, tnum_q, 2'b00};
        csp_we        = 1'b0;
        csp_new       = '0;
        psw_we        = 1'b0;
        psw_new       = {lvl_q, psw_q[KEEP_W-1:0]};
        unique case (state_q)
            ST_IDLE: begin
                busy          = 1'b0;
                sw_ack        = (ev == EV_SW);
                irq_ack       = (ev == EV_IRQ);
                insn_complete = (ev == EV_HW) && !cancel;
                insn_cancel   = (ev == EV_HW) && cancel;
            end
            ST_PUSH_PSW: begin
                mem_we    = 1'b1;
                sp_we     = 1'b1;
                mem_wdata = psw_q;
            end
            ST_PUSH_CSP: begin
                mem_we    = 1'b1;
                sp_we     = 1'b1;
                mem_wdata = {{(WORD_W-SEG_W){1'b0}}, csp_q};
            end
            ST_PUSH_IP: begin
                mem_we    = 1'b1;
                sp_we     = 1'b1;
                mem_wdata = ip_q;
            end
            ST_LOAD: begin
                done   = 1'b1;
                ip_we  = 1'b1;
                csp_we = seg_q;
                psw_we = (kind_q != EV_SW);
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_ack,
    input logic        irq_ack,
    input logic        insn_complete,
    input logic        insn_cancel,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        ip_we,
    input logic        csp_we,
    input logic [7:0]  csp_new,
    input logic [3:0]  irq_level,
    input logic [15:0] psw_in
);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && ip_we));

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ack || irq_ack || insn_complete || insn_cancel) |=> busy);

    assert_push_descends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd2));

    assert_csp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        csp_we |-> (csp_new == 8'h00 && done));

    assert_sw_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |-> !irq_ack);

    assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_ack, irq_ack, insn_complete, insn_cancel}));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_level > psw_in[15:12]));

    assert_no_ack_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(sw_ack || irq_ack || insn_complete || insn_cancel));

endmodule

bind trap_seq trap_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_ack        (sw_ack),
    .irq_ack       (irq_ack),
    .insn_complete (insn_complete),
    .insn_cancel   (insn_cancel),
    .busy          (busy),
    .done          (done),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .ip_we         (ip_we),
    .csp_we        (csp_we),
    .csp_new       (csp_new),
    .irq_level     (irq_level),
    .psw_in        (psw_in)
);

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/1ps
module trap_seq_tb_top;

    localparam logic [55:0] TB_TNUM   = {7'h0F, 7'h0E, 7'h0D, 7'h0C,
                                         7'h0B, 7'h0A, 7'h04, 7'h02};
    localparam logic [7:0]  TB_CANCEL = 8'b1010_0110;
    localparam int K_NONE = 0, K_HW = 1, K_SW = 2, K_IRQ = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic seg_en = 0, sw_req = 0, irq_req = 0;
    logic [6:0] sw_num = 0, irq_num = 0;
    logic [7:0] hw_cond = 0, csp_in = 0;
    logic [3:0] irq_level = 0;
    logic [15:0] psw_in = 0, ip_in = 0, sp_in = 0;
    logic sw_ack, irq_ack, insn_complete, insn_cancel, busy, done;
    logic mem_we, sp_we, ip_we, csp_we, psw_we;
    logic [15:0] mem_addr, mem_wdata, sp_next, ip_new, psw_new;
    logic [7:0] csp_new;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] pend_m = 0;

    always #10 clk = ~clk;

    trap_seq #(.HW_TNUM(TB_TNUM), .HW_CANCEL(TB_CANCEL)) dut_i (
        .clk(clk), .rst_n(rst_n), .seg_en(seg_en), .sw_req(sw_req), .sw_num(sw_num),
        .hw_cond(hw_cond), .irq_req(irq_req), .irq_level(irq_level), .irq_num(irq_num),
        .psw_in(psw_in), .csp_in(csp_in), .ip_in(ip_in), .sp_in(sp_in),
        .sw_ack(sw_ack), .irq_ack(irq_ack), .insn_complete(insn_complete),
        .insn_cancel(insn_cancel), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_we(sp_we), .sp_next(sp_next),
        .ip_we(ip_we), .ip_new(ip_new), .csp_we(csp_we), .csp_new(csp_new),
        .psw_we(psw_we), .psw_new(psw_new)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic apply(input bit seg, input logic [15:0] sp, input logic [15:0] psw,
                         input logic [7:0] csp, input logic [15:0] ip,
                         input bit sw, input logic [6:0] swn, input bit irq,
                         input logic [3:0] lvl, input logic [6:0] inum, input logic [7:0] hw);
        seg_en = seg; sp_in = sp; psw_in = psw; csp_in = csp; ip_in = ip;
        sw_req = sw; sw_num = swn; irq_req = irq; irq_level = lvl; irq_num = inum;
        hw_cond = hw;
    endtask

    // One push cycle check, at the negedge after the state register moved
    task automatic chk_push(input string req, input logic [15:0] addr, input logic [15:0] data);
        chk({req, " write"}, {sp_we, mem_we, busy}, 3'b111);
        chk({req, " addr"}, mem_addr, addr);
        chk({req, " sp_next"}, sp_next, addr);
        chk({req, " data"}, mem_wdata, data);
        chk("R13 no ack while busy", {sw_ack, irq_ack, insn_complete, insn_cancel}, 4'b0);
    endtask

    // Called right after inputs are applied in an idle cycle
    task automatic run_entry(input int kind, input logic [6:0] tn, input bit canc, input bit keep);
        logic [15:0] sp0, psw0, ip0; logic [7:0] csp0; bit seg0; logic [3:0] lvl0;
        logic [15:0] a;
        sp0 = sp_in; psw0 = psw_in; ip0 = ip_in; csp0 = csp_in; seg0 = seg_en; lvl0 = irq_level;
        #1;
        chk("R12/R8 acks", {sw_ack, irq_ack, insn_complete, insn_cancel},
            {kind == K_SW, kind == K_IRQ, kind == K_HW && !canc, kind == K_HW && canc});
        chk("R11 idle busy", busy, 1'b0);
        @(negedge clk);
        if (!keep) begin sw_req = 0; irq_req = 0; end
        hw_cond = 0;
        #1;
        a = sp0 - 16'd2;
        chk_push("R3 psw push", a, psw0);
        if (seg0) begin
            @(negedge clk); #1;
            a = a - 16'd2;
            chk_push("R3 csp push", a, {8'h00, csp0});
        end
        @(negedge clk); #1;
        a = a - 16'd2;
        chk_push(seg0 ? "R3 ip push" : "R4 ip push", a, ip0);
        @(negedge clk); #1;
        chk("R11 load done/busy", {done, busy, ip_we, mem_we}, 4'b1110);
        chk("R2 vector", ip_new, {7'h0, tn, 2'b00});
        chk("R5/R4 csp_we", csp_we, seg0);
        if (seg0) chk("R5 csp zero", csp_new, 8'h00);
        chk("R6 psw_we", psw_we, kind != K_SW);
        if (kind == K_HW) chk("R8 psw level", psw_new, {4'hF, psw0[11:0]});
        if (kind == K_IRQ) chk("R7 psw level", psw_new, {lvl0, psw0[11:0]});
        @(negedge clk); #1;
        chk("R11 busy drops", {busy, done, mem_we}, 3'b000);
    endtask

    // Predict winner from the bench model and run it
    task automatic step();
        logic [7:0] eff; int idx;
        eff = pend_m | hw_cond;
        idx = -1;
        for (int i = 7; i >= 0; i--) if (eff[i]) idx = i;
        if (idx >= 0) begin
            pend_m = eff & ~(8'h1 << idx);
            run_entry(K_HW, TB_TNUM[idx*7 +: 7], TB_CANCEL[idx], 0);
        end else if (sw_req) begin
            run_entry(K_SW, sw_num, 0, 0);
        end else if (irq_req && irq_level > psw_in[15:12]) begin
            run_entry(K_IRQ, irq_num, 0, 0);
        end else begin
            #1;
            chk("R7 no accept", {sw_ack, irq_ack, insn_complete, insn_cancel}, 4'b0);
            @(negedge clk);
            sw_req = 0; irq_req = 0; hw_cond = 0;
            #1;
            chk("R7 stays idle", {busy, mem_we}, 2'b00);
        end
    endtask

    task automatic drain();
        while (pend_m != 0) begin
            apply($urandom % 2, 16'h8000, 16'h1234, 8'h05, 16'h0100, 0, 0, 0, 0, 0, 8'h00);
            step();
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0101));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", {busy, done, mem_we, sp_we, ip_we, csp_we, psw_we,
            sw_ack, irq_ack, insn_complete, insn_cancel}, 11'b0);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 nothing pending", {busy, insn_complete, insn_cancel}, 3'b0);

        // R2: vector range boundaries, with and without segmentation (R3, R4, R5)
        @(negedge clk);
        apply(1, 16'hFC00, 16'h3A55, 8'h7E, 16'h4442, 1, 7'd127, 0, 0, 0, 0); step();
        apply(0, 16'h0200, 16'h5001, 8'h33, 16'h0ABC, 1, 7'd0, 0, 0, 0, 0); step();

        // R7: equal level refused, higher accepted
        apply(1, 16'h9000, 16'h6000, 8'h01, 16'h1111, 0, 0, 1, 4'd6, 7'd40, 0); step();
        apply(1, 16'h9000, 16'h6000, 8'h01, 16'h1111, 0, 0, 1, 4'd7, 7'd40, 0); step();

        // R12: software beats eligible interrupt; R6 no irq_ack
        apply(1, 16'h7000, 16'h2000, 8'h02, 16'h2222, 1, 7'd9, 1, 4'd15, 7'd50, 0); step();

        // R8: hardware beats both, even highest interrupt level
        apply(1, 16'h7000, 16'hF000, 8'h02, 16'h2222, 1, 7'd9, 1, 4'd15, 7'd50, 8'h10); step();
        sw_req = 1; sw_num = 7'd9; step();

        // R9, R10: all eight sources in one cycle, drained in index order
        apply(1, 16'h6000, 16'h0F0F, 8'h44, 16'h3333, 0, 0, 0, 0, 0, 8'hFF); step();
        drain();

        // R13: software request held across a busy entry is taken afterwards
        apply(0, 16'h5000, 16'h1000, 8'h09, 16'h4444, 1, 7'd21, 0, 0, 0, 0);
        run_entry(K_SW, 7'd21, 0, 1);
        sw_num = 7'd22;
        run_entry(K_SW, 7'd22, 0, 0);

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            apply($urandom % 2, 16'(($urandom % 16'h7000) * 2 + 16'h1000),
                  16'($urandom), 8'($urandom), 16'($urandom),
                  ($urandom % 3) == 0, 7'($urandom), ($urandom % 2) == 0,
                  4'($urandom), 7'($urandom),
                  (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
            step();
            if (($urandom % 3) == 0) drain();
        end
        drain();

        finish_run();
    end

endmodule